// File: doc/BRIEF.md
# Saturating Q15 Vector Dot-Product Accumulator

This unit is a pipelined arithmetic stage that takes four 16-bit two's-complement fractional samples per issue, packed into a 64-bit word with lane 0 in the lowest bits. Each enabled lane is multiplied by the matching lane of a second 64-bit operand, or by itself in square mode. The product is doubled to Q31, and the one product that cannot be doubled is clamped. The four lane results are then folded into a running sum.

Two accumulation modes are offered. In saturating mode the sum is 32 bits wide. Lane results are added one after another from lane 0 to lane 3, and the sum is clamped after every step, so the result matches a scalar loop over the same samples bit for bit. In wide mode the sum uses a 40-bit accumulator with eight guard bits and wraps without clamping. A narrowed 32-bit view of that accumulator is always available at the output.

A per-lane enable mask handles loop tails. A clear flag sent with a vector restarts the sum from zero. A sticky flag records any clamp.

Top module: `q15_vdot_mac`

## Requirements
- R1: An enabled lane contributes twice the signed product of its two samples (Q15 x Q15 to Q31); lane i occupies bits [16i+15:16i] of each operand.
- R2: When both samples of an enabled lane are 0x8000, the lane contributes 0x7FFFFFFF and the overflow flag is set.
- R3: In saturating mode (in_wide=0) the lane results are added to the 32-bit running sum in order lane 0, 1, 2, 3. An add step overflows only when both addends share a sign bit and the raw sum's sign differs; it then clamps to 0x80000000 if the running sum was negative and to 0x7FFFFFFF otherwise.
- R4: A lane whose in_mask bit i is 0 contributes zero and cannot set the overflow flag.
- R5: In wide mode (in_wide=1) the four lane results, sign-extended to 40 bits, are added to the 40-bit accumulator modulo 2^40 without clamping, and no add step sets the overflow flag.
- R6: A vector sent with in_clear=1 is accumulated starting from zero, and the overflow flag restarts from that vector's own clamps.
- R7: With in_square=1 each lane uses its in_a sample as both factors, and in_b is ignored.
- R8: After reset in_ready is 1, one vector is accepted per cycle, and each accepted vector raises out_valid for one cycle exactly two clock edges after the edge that accepts it.
- R9: out_ovf is sticky: it stays set across later vectors until a vector with in_clear=1 is accepted.
- R10: While rst_n is low (synchronous), out_valid, in_ready and out_ovf are 0 and the accumulator is zero.
- R11: out_sum is the accumulator clamped to the signed 32-bit range. A saturating-mode vector that follows wide-mode accumulation starts from this clamped value, and the 40-bit accumulator then holds it sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand vector present |
| in_ready | output | 1 | Unit accepts a vector this cycle |
| in_a | input | 64 | Four Q15 samples, lane 0 in the low bits |
| in_b | input | 64 | Four Q15 multiplier samples |
| in_mask | input | 4 | Lane enables, bit i for lane i |
| in_square | input | 1 | Square in_a lanes instead of multiplying by in_b |
| in_wide | input | 1 | 1: 40-bit wrapping mode, 0: 32-bit saturating mode |
| in_clear | input | 1 | Start this vector from a zero sum and clear the flag |
| out_valid | output | 1 | Accumulator updated by a vector |
| out_sum | output | 32 | Accumulator clamped to 32 bits |
| out_acc | output | 40 | Full 40-bit accumulator |
| out_ovf | output | 1 | Sticky clamp indicator |

## Verification
A table of single, cleared vectors covers positive, negative and mixed products, the -1 x -1 corner, exact reach of the negative limit against real overflow, square mode with a misleading in_b, and partial and empty masks over corner-valued lanes. One entry overflows on lane 1 and is pulled back by a negative lane 2, so only a lane-ordered, per-step clamp yields its result, where a single wide sum would not. Directed sequences chain vectors without clear, to tell the sticky flag from a per-vector flag, and issue back-to-back vectors to show single-cycle throughput. A wide-then-saturating sequence separates guard-bit growth and wrapping from the clamped view and from the mode hand-over.

// File: rtl/vmac_pkg.sv
// Shared sizes and types for the Q15 vector dot-product accumulator.
package vmac_pkg;
    localparam int SAMPLE_W = 16;   // bits per fractional sample
    localparam int LANE_N   = 4;    // samples per vector operand
    localparam int GUARD_W  = 8;    // extra accumulator bits in wide mode

    typedef enum logic {
        ACC_SAT32  = 1'b0,
        ACC_WIDE40 = 1'b1
    } acc_mode_e;

    typedef struct packed {
        logic      valid;
        logic      clear;
        acc_mode_e mode;
    } stage_ctrl_t;
endpackage

// File: rtl/q15_acc_narrow.sv
// q15_acc_narrow: clamps a wide two's-complement accumulator to OUT_W bits.
// Assumes ACC_W > OUT_W. Purely combinational.
module q15_acc_narrow #(
    parameter int ACC_W = 40,
    parameter int OUT_W = 32
) (
    input  logic [ACC_W-1:0] acc,
    output logic [OUT_W-1:0] narrowed
);
    localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};
    localparam int HI_W = ACC_W - OUT_W + 1;

    logic [HI_W-1:0] hi;

    // Keep the low bits when all upper bits copy the sign, otherwise clamp.
    always_comb begin
        hi = acc[ACC_W-1:OUT_W-1];
        if (hi == '0 || hi == '1) narrowed = acc[OUT_W-1:0];
        else                      narrowed = acc[ACC_W-1] ? NEG_LIM : POS_LIM;
    end
endmodule

// File: rtl/q15_lane_mul.sv
// q15_lane_mul: one lane's fractional multiply with doubling and the
// -1 x -1 clamp, registered as the first pipeline stage. A disabled lane
// registers zero and no clamp. Holds its value when ld is low.
module q15_lane_mul #(
    parameter int SAMPLE_W = 16,
    localparam int PROD_W  = 2 * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] a,
    input  logic [SAMPLE_W-1:0] b,
    output logic [PROD_W-1:0]   q_prod,
    output logic                q_sat
);
    localparam logic [PROD_W-1:0]   POS_LIM  = {1'b0, {(PROD_W-1){1'b1}}};
    localparam logic [PROD_W-1:0]   CORNER   = {2'b01, {(PROD_W-2){1'b0}}};
    localparam logic [SAMPLE_W-1:0] MINUS_ONE = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [PROD_W-1:0] raw;
    logic [PROD_W-1:0] nxt_prod;
    logic              nxt_sat;

    // Signed product, doubled, with the single unrepresentable case clamped.
    always_comb begin
        raw      = PROD_W'(signed'(a)) * PROD_W'(signed'(b));
        nxt_sat  = en && (raw == CORNER);
        if (!en)         nxt_prod = '0;
        else if (nxt_sat) nxt_prod = POS_LIM;
        else             nxt_prod = raw << 1;
    end

    // Stage register for the lane result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_prod <= '0;
            q_sat  <= 1'b0;
        end else if (ld) begin
            q_prod <= nxt_prod;
            q_sat  <= nxt_sat;
        end
    end

    a_r2_corner_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && en && a == MINUS_ONE && b == MINUS_ONE) |=> (q_prod == POS_LIM && q_sat));

    a_r4_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !en) |=> (q_prod == '0 && !q_sat));
endmodule

// File: rtl/q15_lane_fold.sv
// q15_lane_fold: folds the lane results into the accumulator. Saturating
// mode walks lanes 0..N-1 with a clamp after each add. Wide mode adds
// sign-extended results modulo 2^ACC_W. Purely combinational.
module q15_lane_fold #(
    parameter int LANE_N = 4,
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic [ACC_W-1:0]             acc_in,
    input  logic [LANE_N-1:0][PROD_W-1:0] prods,
    input  logic                          wide,
    input  logic                          clear,
    output logic [ACC_W-1:0]              acc_out,
    output logic                          add_ovf
);
    localparam logic [PROD_W-1:0] POS_LIM = {1'b0, {(PROD_W-1){1'b1}}};
    localparam logic [PROD_W-1:0] NEG_LIM = {1'b1, {(PROD_W-1){1'b0}}};

    // One saturating add; returns {overflow, result}.
    function automatic logic [PROD_W:0] sat_step(input logic [PROD_W-1:0] r,
                                                 input logic [PROD_W-1:0] p);
        logic [PROD_W-1:0] s;
        s = r + p;
        if (r[PROD_W-1] == p[PROD_W-1] && s[PROD_W-1] != r[PROD_W-1])
            return {1'b1, r[PROD_W-1] ? NEG_LIM : POS_LIM};
        return {1'b0, s};
    endfunction

    logic [ACC_W-1:0]  start;
    logic [PROD_W-1:0] start_n;
    logic [PROD_W-1:0] run;
    logic [ACC_W-1:0]  wide_sum;
    logic [PROD_W:0]   step;
    logic              sat_any;

    assign start = clear ? '0 : acc_in;

    q15_acc_narrow #(.ACC_W(ACC_W), .OUT_W(PROD_W)) u_start_narrow (
        .acc      (start),
        .narrowed (start_n)
    );

    // Lane-ordered reduction in both modes; the mode picks the result.
    always_comb begin
        run      = start_n;
        wide_sum = start;
        sat_any  = 1'b0;
        step     = '0;
        for (int i = 0; i < LANE_N; i++) begin
            wide_sum = wide_sum + ACC_W'(signed'(prods[i]));
            step     = sat_step(run, prods[i]);
            sat_any  = sat_any | step[PROD_W];
            run      = step[PROD_W-1:0];
        end
        if (wide) begin
            acc_out = wide_sum;
            add_ovf = 1'b0;
        end else begin
            acc_out = ACC_W'(signed'(run));
            add_ovf = sat_any;
        end
    end
endmodule

// File: rtl/q15_vdot_mac.sv
// q15_vdot_mac: four-lane Q15 multiply and saturating dot-product
// accumulator. Stage 1 registers lane products; stage 2 updates the
// accumulator. Never stalls: in_ready is high whenever out of reset.
module q15_vdot_mac #(
    parameter int SAMPLE_W = vmac_pkg::SAMPLE_W,
    parameter int LANE_N   = vmac_pkg::LANE_N,
    parameter int GUARD_W  = vmac_pkg::GUARD_W,
    localparam int VEC_W   = SAMPLE_W * LANE_N,
    localparam int PROD_W  = 2 * SAMPLE_W,
    localparam int ACC_W   = PROD_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VEC_W-1:0]  in_a,
    input  logic [VEC_W-1:0]  in_b,
    input  logic [LANE_N-1:0] in_mask,
    input  logic              in_square,
    input  logic              in_wide,
    input  logic              in_clear,
    output logic              out_valid,
    output logic [PROD_W-1:0] out_sum,
    output logic [ACC_W-1:0]  out_acc,
    output logic              out_ovf
);
    import vmac_pkg::*;

    logic                         ready_q;
    logic                         take;
    stage_ctrl_t                  s1_q;
    logic [LANE_N-1:0][PROD_W-1:0] s1_prod;
    logic [LANE_N-1:0]            s1_sat;
    logic [ACC_W-1:0]             acc_q;
    logic [ACC_W-1:0]             acc_nxt;
    logic                         add_ovf;
    logic                         ovf_q;
    logic                         vld_q;

    assign take = in_valid && ready_q;

    // Ready comes up on the first edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Stage 1: one multiplier per lane.
    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        q15_lane_mul #(.SAMPLE_W(SAMPLE_W)) u_mul (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (take),
            .en     (in_mask[g]),
            .a      (in_a[g*SAMPLE_W +: SAMPLE_W]),
            .b      (in_square ? in_a[g*SAMPLE_W +: SAMPLE_W]
                               : in_b[g*SAMPLE_W +: SAMPLE_W]),
            .q_prod (s1_prod[g]),
            .q_sat  (s1_sat[g])
        );
    end

    // Stage 1 control travelling with the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '{valid: 1'b0, clear: 1'b0, mode: ACC_SAT32};
        end else begin
            s1_q.valid <= take;
            if (take) begin
                s1_q.clear <= in_clear;
                s1_q.mode  <= acc_mode_e'(in_wide);
            end
        end
    end

    q15_lane_fold #(.LANE_N(LANE_N), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_fold (
        .acc_in  (acc_q),
        .prods   (s1_prod),
        .wide    (s1_q.mode == ACC_WIDE40),
        .clear   (s1_q.clear),
        .acc_out (acc_nxt),
        .add_ovf (add_ovf)
    );

    // Stage 2: accumulator, sticky flag and output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= s1_q.valid;
            if (s1_q.valid) begin
                acc_q <= acc_nxt;
                ovf_q <= (ovf_q && !s1_q.clear) || (|s1_sat) || add_ovf;
            end
        end
    end

    q15_acc_narrow #(.ACC_W(ACC_W), .OUT_W(PROD_W)) u_out_narrow (
        .acc      (acc_q),
        .narrowed (out_sum)
    );

    assign in_ready  = ready_q;
    assign out_valid = vld_q;
    assign out_acc   = acc_q;
    assign out_ovf   = ovf_q;

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##2 out_valid);

    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf && !(s1_q.valid && s1_q.clear)) |=> out_ovf);

    a_r3_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && s1_q.mode == ACC_SAT32) |=>
        (acc_q[ACC_W-1:PROD_W-1] == '0 || acc_q[ACC_W-1:PROD_W-1] == '1));

    a_r6_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && s1_q.clear && s1_sat == '0 && !add_ovf) |=> !out_ovf);

    a_r5_wide_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && s1_q.mode == ACC_WIDE40) |-> !add_ovf);
endmodule

// File: tb/q15_vdot_mac_bench.sv
`timescale 1ns/1ps
module q15_vdot_mac_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready;
    logic [63:0] in_a, in_b;
    logic [3:0]  in_mask;
    logic        in_square, in_wide, in_clear;
    logic        out_valid;
    logic [31:0] out_sum;
    logic [39:0] out_acc;
    logic        out_ovf;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    q15_vdot_mac u_q15_vdot_mac (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_mask(in_mask), .in_square(in_square),
        .in_wide(in_wide), .in_clear(in_clear), .out_valid(out_valid),
        .out_sum(out_sum), .out_acc(out_acc), .out_ovf(out_ovf)
    );

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [3:0]  m;
        logic        sq;
        logic [31:0] s;
        logic        o;
    } vec_t;

    // Cleared saturating-mode vectors with hand-computed results.
    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{64'h0000_0000_0000_4000, 64'h0000_0000_0000_4000, 4'hF, 1'b0, 32'h2000_0000, 1'b0}, // R1 0.5*0.5
        '{64'h4000_4000_4000_4000, 64'h4000_4000_4000_4000, 4'hF, 1'b0, 32'h7FFF_FFFF, 1'b1}, // R3 positive clamp
        '{64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 4'hF, 1'b0, 32'h7FFF_FFFF, 1'b1}, // R2 corner
        '{64'h0000_0000_4000_8000, 64'h0000_0000_4000_8000, 4'hE, 1'b0, 32'h2000_0000, 1'b0}, // R4 corner lane masked
        '{64'h0000_0000_4000_8000, 64'h0000_0000_4000_4000, 4'hF, 1'b0, 32'hE000_0000, 1'b0}, // R1 mixed signs
        '{64'h8000_8000_8000_8000, 64'h4000_4000_4000_4000, 4'hF, 1'b0, 32'h8000_0000, 1'b1}, // R3 negative clamp
        '{64'h0000_0000_2000_4000, 64'h7FFF_7FFF_7FFF_7FFF, 4'hF, 1'b1, 32'h2800_0000, 1'b0}, // R7 square
        '{64'h0000_8000_4000_7FFF, 64'h0000_4000_4000_7FFF, 4'hF, 1'b0, 32'h3FFF_FFFF, 1'b1}, // R3 lane order
        '{64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 4'h0, 1'b0, 32'h0000_0000, 1'b0}, // R4 all masked
        '{64'h8000_8000_8000_2000, 64'h8000_8000_8000_2000, 4'h1, 1'b0, 32'h0800_0000, 1'b0}  // R4 tail of one
    };

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [3:0] m,
                         input logic sq, input logic wd, input logic clr);
        in_valid = 1'b1; in_a = a; in_b = b; in_mask = m;
        in_square = sq; in_wide = wd; in_clear = clr;
    endtask

    // Drive at a falling edge, then sample two rising edges later.
    task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [3:0] m,
                        input logic sq, input logic wd, input logic clr);
        drive(a, b, m, sq, wd, clr);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [31:0] s,
                              input logic [39:0] acc, input logic o);
        chk({tag, " valid"}, 40'(out_valid), 40'd1);
        chk({tag, " sum"},   40'(out_sum),   40'(s));
        chk({tag, " acc"},   out_acc,        acc);
        chk({tag, " ovf"},   40'(out_ovf),   40'(o));
    endtask

    function automatic logic [39:0] sx(input logic [31:0] v);
        return {{8{v[31]}}, v};
    endfunction

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(64'h4000_4000_4000_4000, 64'h4000_4000_4000_4000, 4'hF, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10 reset out_valid", 40'(out_valid), 40'd0);
        chk("R10 reset in_ready",  40'(in_ready),  40'd0);
        chk("R10 reset out_ovf",   40'(out_ovf),   40'd0);
        chk("R10 reset out_acc",   out_acc,        40'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 ready after reset", 40'(in_ready), 40'd1);

        // Table walk: each vector starts from a cleared sum.
        for (int i = 0; i < NV; i++) begin
            send(TBL[i].a, TBL[i].b, TBL[i].m, TBL[i].sq, 1'b0, 1'b1);
            expect_out($sformatf("R1/R3 table %0d", i), TBL[i].s, sx(TBL[i].s), TBL[i].o);
        end
        @(negedge clk);
        chk("R8 single-cycle strobe", 40'(out_valid), 40'd0);

        // R9 sticky flag across a harmless vector, then R6 clear.
        send(64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 4'hF, 1'b0, 1'b0, 1'b1);
        expect_out("R9 set", 32'h7FFF_FFFF, sx(32'h7FFF_FFFF), 1'b1);
        send(64'h0, 64'h0, 4'hF, 1'b0, 1'b0, 1'b0);
        expect_out("R9 hold", 32'h7FFF_FFFF, sx(32'h7FFF_FFFF), 1'b1);
        send(64'h0000_0000_0000_4000, 64'h0000_0000_0000_4000, 4'hF, 1'b0, 1'b0, 1'b1);
        expect_out("R6 clear", 32'h2000_0000, sx(32'h2000_0000), 1'b0);
        send(64'h0000_0000_0000_4000, 64'h0000_0000_0000_4000, 4'hF, 1'b0, 1'b0, 1'b0);
        expect_out("R3 running sum", 32'h4000_0000, sx(32'h4000_0000), 1'b0);

        // R5 wide mode growth into guard bits, then R11 hand-over.
        send(64'h4000_4000_4000_4000, 64'h4000_4000_4000_4000, 4'hF, 1'b0, 1'b1, 1'b1);
        expect_out("R5 wide first", 32'h7FFF_FFFF, 40'h00_8000_0000, 1'b0);
        send(64'h4000_4000_4000_4000, 64'h4000_4000_4000_4000, 4'hF, 1'b0, 1'b1, 1'b0);
        expect_out("R5 wide second", 32'h7FFF_FFFF, 40'h01_0000_0000, 1'b0);
        send(64'h0, 64'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        expect_out("R11 mode switch", 32'h7FFF_FFFF, 40'h00_7FFF_FFFF, 1'b0);
        send(64'h8000_8000_8000_8000, 64'h7FFF_7FFF_7FFF_7FFF, 4'hF, 1'b0, 1'b1, 1'b1);
        expect_out("R5 wide negative", 32'h8000_0000, 40'hFE_0004_0000, 1'b0);

        // R8 back-to-back vectors, one result per cycle.
        drive(64'h0000_0000_0000_4000, 64'h0000_0000_0000_4000, 4'hF, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R8 no early strobe", 40'(out_valid), 40'd0);
        in_clear = 1'b0;
        @(negedge clk);
        expect_out("R8 stream 1", 32'h2000_0000, sx(32'h2000_0000), 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out("R8 stream 2", 32'h4000_0000, sx(32'h4000_0000), 1'b0);
        @(negedge clk);
        expect_out("R8 stream 3", 32'h6000_0000, sx(32'h6000_0000), 1'b0);
        @(negedge clk);
        chk("R8 stream end", 40'(out_valid), 40'd0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule